// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

An eight-pin general-purpose I/O port sitting on a small byte-wide processor bus. Software reaches three registers through an address, a write-data byte, a read-data byte and separate read and write strobes: an output latch, a direction mask and a per-pin pull-up select. For every pin the block drives an output enable, an output level and a weak pull-up enable toward the pad, and it receives the sampled pin level back.

Reading the data address never returns the output latch. It returns the pin levels as seen through a two-stage synchronizer, so software always observes the real state of the pin. The direction mask is write-only. A stop flag from the power-management logic turns off every output driver while the chip is halted. Pins whose pull-up is selected are then held high by the pad, and the others float. Reset overrides all of this: drivers and pull-ups stay off for as long as reset is active. Reset asserts asynchronously and is released on a clock edge after two flops.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the direction mask and the pull-up select are 0x00, every bit of `pad_oe` and `pad_pu` is 0, and `bus_rdata` reads 0x00.
- R2: A write strobe at address 0x0C loads the output latch. From the next clock edge on, `pad_out[i]` equals latch bit i on every pin whose `pad_oe[i]` is 1, and it is 0 on every other pin.
- R3: A write strobe at address 0x0D loads the direction mask. A 1 in bit i sets `pad_oe[i]` and a 0 clears it (pin i is an input), starting at the next clock edge, while stop is 0.
- R4: The direction mask is write-only. A read strobe at 0x0D returns 0x00 on `bus_rdata` whatever mask is stored.
- R5: The pull-up select at address 0x71 can be written and read back. A 1 in bit i selects the pull-up of pin i.
- R6: A read strobe at 0x0C returns the pin levels (bit i is 1 when pin i is high). A pin change is seen by a read strobe sampled on the third clock edge after the change or later. A read strobe on the first edge after the change still returns the old level.
- R7: While `stop_mode` is 1, `pad_oe` and `pad_out` are 0 and `pad_pu` equals the pull-up select. While `stop_mode` is 0, `pad_pu` is 0.
- R8: While `rst_n` is low, `pad_pu` and `pad_oe` are 0 for every pin, even when `stop_mode` is 1 and pull-ups were selected.
- R9: A read strobe at any address other than 0x0C and 0x71 returns 0x00. A write to such an address changes no register.
- R10: `bus_rdata` is registered. It updates on the clock edge that samples a read strobe and holds its value in every cycle without one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe, sampled on the rising edge |
| bus_rdata | output | 8 | Registered read data |
| stop_mode | input | 1 | Chip stop flag |
| pin_in | input | 8 | Sampled pin levels |
| pad_oe | output | 8 | Per-pin output driver enable |
| pad_out | output | 8 | Per-pin output level |
| pad_pu | output | 8 | Per-pin weak pull-up enable |

## Verification
Register writes reach `pad_oe` and `pad_out` on the edge that samples the strobe. `stop_mode` and `rst_n` act on the pad outputs without any clock. Read data is due on the edge that samples the read strobe. A pin change reaches that read only from the third edge after the change. The bench drives inputs at the falling edge and compares every output against a behavioural model 3 ns after each rising edge, so each result is checked in the cycle it falls due. A dedicated read on the first edge after a pin change confirms that the stale value is returned there.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Which register a bus address selects.
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LAT  = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_PULL = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_int
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  // Assertion is asynchronous; release ripples through the chain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_int = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  // No reset: these flops only carry pad levels.
  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          stage_q[s] <= pin_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign pin_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int                WIDTH     = 8,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ADDR_LAT  = 'h0C,
  parameter logic [ADDR_W-1:0] ADDR_DIR  = 'h0D,
  parameter logic [ADDR_W-1:0] ADDR_PULL = 'h71
) (
  input  logic              clk,
  input  logic              rst_n_int,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  lat_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  pull_q,
  output logic [WIDTH-1:0]  rdata_q
);

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    reg_sel_e sel;
    if (a == ADDR_LAT) begin
      sel = SEL_LAT;
    end else if (a == ADDR_DIR) begin
      sel = SEL_DIR;
    end else if (a == ADDR_PULL) begin
      sel = SEL_PULL;
    end else begin
      sel = SEL_NONE;
    end
    return sel;
  endfunction

  reg_sel_e         sel;
  logic             lat_en, dir_en, pull_en, rd_en;
  logic [WIDTH-1:0] lat_d, dir_d, pull_d, rdata_d;

  // Next-state and clock-enable logic.
  always_comb begin
    sel     = decode(bus_addr);
    lat_en  = bus_wr && (sel == SEL_LAT);
    dir_en  = bus_wr && (sel == SEL_DIR);
    pull_en = bus_wr && (sel == SEL_PULL);
    rd_en   = bus_rd;
    lat_d   = bus_wdata;
    dir_d   = bus_wdata;
    pull_d  = bus_wdata;
    case (sel)
      SEL_LAT:  rdata_d = pin_sync;
      SEL_PULL: rdata_d = pull_q;
      default:  rdata_d = '0;
    endcase
  end

  // The output latch has no defined reset value.
  always_ff @(posedge clk) begin
    if (lat_en && rst_n_int) begin
      lat_q <= lat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      dir_q   <= '0;
      pull_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (dir_en) begin
        dir_q <= dir_d;
      end
      if (pull_en) begin
        pull_q <= pull_d;
      end
      if (rd_en) begin
        rdata_q <= rdata_d;
      end
    end
  end

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             rst_n_int,
  input  logic             stop_mode,
  input  logic [WIDTH-1:0] lat_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] pull_q,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_pu
);

  logic drive_ok;
  logic pull_ok;

  always_comb begin
    drive_ok = rst_n_int && !stop_mode;
    pull_ok  = rst_n_int && stop_mode;
  end

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_pin
      always_comb begin
        pad_oe[i]  = drive_ok && dir_q[i];
        pad_out[i] = drive_ok && dir_q[i] && lat_q[i];
        pad_pu[i]  = pull_ok && pull_q[i];
      end
    end
  endgenerate

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int                WIDTH       = 8,
  parameter int                ADDR_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter int                RST_STAGES  = 2,
  parameter logic [ADDR_W-1:0] ADDR_LAT    = 'h0C,
  parameter logic [ADDR_W-1:0] ADDR_DIR    = 'h0D,
  parameter logic [ADDR_W-1:0] ADDR_PULL   = 'h71
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic              stop_mode,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_pu
);

  logic             rst_n_int;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] lat_q, dir_q, pull_q;

  gpio_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_int (rst_n_int)
  );

  gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .pin_in   (pin_in),
    .pin_sync (pin_sync)
  );

  gpio_regs #(
    .WIDTH(WIDTH), .ADDR_W(ADDR_W),
    .ADDR_LAT(ADDR_LAT), .ADDR_DIR(ADDR_DIR), .ADDR_PULL(ADDR_PULL)
  ) u_regs (
    .clk       (clk),
    .rst_n_int (rst_n_int),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .pin_sync  (pin_sync),
    .lat_q     (lat_q),
    .dir_q     (dir_q),
    .pull_q    (pull_q),
    .rdata_q   (bus_rdata)
  );

  gpio_pad_ctrl #(.WIDTH(WIDTH)) u_pad (
    .rst_n_int (rst_n_int),
    .stop_mode (stop_mode),
    .lat_q     (lat_q),
    .dir_q     (dir_q),
    .pull_q    (pull_q),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_pu    (pad_pu)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int                WIDTH     = 8,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ADDR_LAT  = 'h0C,
  parameter logic [ADDR_W-1:0] ADDR_DIR  = 'h0D,
  parameter logic [ADDR_W-1:0] ADDR_PULL = 'h71
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic              stop_mode,
  input logic [WIDTH-1:0]  pad_oe,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  pad_pu
);

  // R4
  dir_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_DIR) |=> (bus_rdata == '0));

  // R9
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != ADDR_LAT && bus_addr != ADDR_PULL) |=> (bus_rdata == '0));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  // R7
  stop_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mode |-> (pad_oe == '0 && pad_out == '0));

  // R7
  run_no_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_mode |-> (pad_pu == '0));

  // R2
  out_only_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & ~pad_oe) == '0));

  // R8
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_pads_off_chk: assert (pad_pu == '0 && pad_oe == '0);
    end
  end

endmodule

bind gpio_port_ctrl gpio_port_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W),
  .ADDR_LAT(ADDR_LAT), .ADDR_DIR(ADDR_DIR), .ADDR_PULL(ADDR_PULL)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .stop_mode (stop_mode),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out),
  .pad_pu    (pad_pu)
);

// File: tb/test_gpio_port_ctrl.sv
`timescale 1ns/1ps
module test_gpio_port_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic       bus_wr, bus_rd, stop_mode;
  logic [7:0] pin_in, pad_oe, pad_out, pad_pu;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;  // 125 MHz

  gpio_port_ctrl i_gpio_port_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .stop_mode(stop_mode), .pin_in(pin_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_lat = 8'h00, m_dir = 8'h00, m_pull = 8'h00, m_rd = 8'h00;
  logic [7:0] pin_hist [$];
  int         rel_cnt = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 0; m_pull = 0; m_rd = 0; rel_cnt = 0;
    end else if (rel_cnt < 2) begin
      rel_cnt++;
    end else begin
      if (bus_rd) begin
        if (bus_addr == 8'h0C)
          m_rd = (pin_hist.size() >= 2) ? pin_hist[pin_hist.size()-2] : 8'h00;
        else if (bus_addr == 8'h71) m_rd = m_pull;
        else m_rd = 8'h00;
      end
      if (bus_wr) begin
        if (bus_addr == 8'h0C) m_lat = bus_wdata;
        if (bus_addr == 8'h0D) m_dir = bus_wdata;
        if (bus_addr == 8'h71) m_pull = bus_wdata;
      end
    end
  end

  always @(posedge clk) begin
    pin_hist.push_back(pin_in);
    if (pin_hist.size() > 4) void'(pin_hist.pop_front());
  end

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  // Compare every clock, 3 ns after the rising edge.
  always @(posedge clk) begin
    #3;
    begin
      bit         live;
      logic [7:0] e_oe, e_pu;
      live = rst_n && (rel_cnt >= 2);
      e_oe = (live && !stop_mode) ? m_dir : 8'h00;
      e_pu = (live && stop_mode) ? m_pull : 8'h00;
      chk(cur_req, "pad_oe", pad_oe, e_oe);
      chk(cur_req, "pad_out", pad_out, e_oe & m_lat);
      chk(cur_req, "pad_pu", pad_pu, e_pu);
      chk(cur_req, "bus_rdata", bus_rdata, rst_n ? m_rd : 8'h00);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_addr = 0; bus_wdata = 0; bus_wr = 0; bus_rd = 0;
    stop_mode = 0; pin_in = 8'h00;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state
    cur_req = "R1";
    chk("R1", "pad_oe", pad_oe, 8'h00);
    chk("R1", "pad_pu", pad_pu, 8'h00);
    bus_read(8'h71);
    chk("R1", "pull readback", bus_rdata, 8'h00);

    // R5: pull-up select read/write
    cur_req = "R5";
    bus_write(8'h71, 8'hA5);
    bus_read(8'h71);
    chk("R5", "pull readback", bus_rdata, 8'hA5);

    // R4: direction write-only
    cur_req = "R4";
    bus_write(8'h0C, 8'h96);
    bus_write(8'h0D, 8'h3C);
    bus_read(8'h0D);
    chk("R4", "dir read", bus_rdata, 8'h00);

    // R3 / R2: direction and latch on pads
    cur_req = "R3";
    chk("R3", "pad_oe", pad_oe, 8'h3C);
    cur_req = "R2";
    chk("R2", "pad_out", pad_out, 8'h96 & 8'h3C);
    bus_write(8'h0C, 8'h69);
    chk("R2", "pad_out new latch", pad_out, 8'h69 & 8'h3C);
    bus_write(8'h0D, 8'hFF);
    chk("R3", "pad_oe all", pad_oe, 8'hFF);
    chk("R2", "pad_out all", pad_out, 8'h69);

    // R6: pin levels through the synchronizer
    cur_req = "R6";
    pin_in = 8'h5A;
    idle(3);
    bus_read(8'h0C);
    chk("R6", "pin read", bus_rdata, 8'h5A);
    @(negedge clk);
    pin_in = 8'hC3;
    bus_addr = 8'h0C; bus_rd = 1'b1;     // strobe on first edge after change
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R6", "stale pin read", bus_rdata, 8'h5A);
    idle(2);
    bus_read(8'h0C);
    chk("R6", "late pin read", bus_rdata, 8'hC3);

    // R10: rdata holds without a strobe
    cur_req = "R10";
    pin_in = 8'h0F;
    idle(5);
    chk("R10", "rdata hold", bus_rdata, 8'hC3);

    // R7: stop mode
    cur_req = "R7";
    @(negedge clk); stop_mode = 1'b1;
    idle(1);
    chk("R7", "pad_oe stop", pad_oe, 8'h00);
    chk("R7", "pad_out stop", pad_out, 8'h00);
    chk("R7", "pad_pu stop", pad_pu, 8'hA5);
    bus_write(8'h71, 8'h3E);
    chk("R7", "pad_pu new", pad_pu, 8'h3E);
    @(negedge clk); stop_mode = 1'b0;
    idle(1);
    chk("R7", "pad_pu run", pad_pu, 8'h00);
    chk("R7", "pad_oe run", pad_oe, 8'hFF);

    // R9: unmapped address
    cur_req = "R9";
    bus_write(8'h0E, 8'h00);
    bus_write(8'h70, 8'h00);
    bus_read(8'h0E);
    chk("R9", "unmapped read", bus_rdata, 8'h00);
    chk("R9", "dir untouched", pad_oe, 8'hFF);
    bus_read(8'h71);
    chk("R9", "pull untouched", bus_rdata, 8'h3E);

    // R8: reset forces pads off even in stop
    cur_req = "R8";
    @(negedge clk); stop_mode = 1'b1;
    idle(1);
    chk("R8", "pad_pu before reset", pad_pu, 8'h3E);
    #1 rst_n = 1'b0;
    #1;
    chk("R8", "pad_pu in reset", pad_pu, 8'h00);
    chk("R8", "pad_oe in reset", pad_oe, 8'h00);
    idle(3);
    chk("R8", "pad_pu held", pad_pu, 8'h00);
    rst_n = 1'b1;
    idle(4);
    cur_req = "R1";
    chk("R1", "pad_pu after reset", pad_pu, 8'h00);
    @(negedge clk); stop_mode = 1'b0;
    bus_read(8'h71);
    chk("R1", "pull cleared", bus_rdata, 8'h00);
    idle(3);

    finish_run();
  end

endmodule